// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block sits between a processor core and a byte-wide system bus. The core issues logical accesses: one of four current segment registers, a 16-bit offset, a byte-or-word size, a direction and, for writes, the data. The block never lets the logical form reach the bus. It takes the selected segment value, shifts it left by four bits, and adds the offset to get a 20-bit physical byte address. Every bus transfer uses that physical address.

A byte access takes one bus cycle. A word access is split into two byte cycles, run in little-endian order. The low byte goes to the computed address. The high byte goes to the address formed from the offset plus one. Each bus cycle raises a one-clock strobe and then waits for a ready reply. For reads, the block assembles the returned bytes and presents them together with a one-cycle done pulse.

A separate load port writes the segment registers. A load never changes an access that has already been accepted.

Top module: `seg_xlate_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done` and `bus_stb` are 0. All segment registers reset to 0000h.
- R2: The bus address of the first byte cycle equals (selected segment × 16 + offset) taken modulo 2^20.
- R3: `req_seg` picks which of the four segment registers forms the address. `seg_ld` with `seg_ld_idx`/`seg_ld_val` sets the register that will be used.
- R4: On a word write, the low data byte (`req_wdata[7:0]`) is written to the first address and the high byte (`req_wdata[15:8]`) to the second.
- R5: A read finishes with `done` high for exactly one cycle. On a word read, `rd_data` then holds the byte from the second address in bits 15:8 and the byte from the first address in bits 7:0.
- R6: A byte access (`req_word`=0) makes exactly one strobe. On a byte read, `rd_data[15:8]` is 0. A word access (`req_word`=1) makes exactly two strobes.
- R7: For the second byte of a word, offset+1 wraps within 16 bits before the segment is added. Offset FFFFh therefore reaches segment × 16 + 0.
- R8: Each `bus_stb` lasts one clock. The next byte cycle, or `done`, comes only in the cycle after `bus_rdy` is sampled high. With a reply delay of L cycles, a word access completes 2L+2 clocks after the accepting edge.
- R9: `busy` rises on the edge that accepts a request and falls when `done` rises. A `req_valid` seen while `busy` is high is ignored: it makes no strobe and changes no address.
- R10: A segment load made while an access is in progress, or in the same cycle as the accepting edge, does not change that access. The next request uses the new value.
- R11: The physical address sum wraps modulo 2^20. Segment FFFFh with offset 0010h gives address 00000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, taken when idle |
| req_seg | input | 2 | Segment register select |
| req_ofs | input | 16 | Effective offset |
| req_word | input | 1 | 1 = word (two bytes), 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data, low byte used for byte writes |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Assembled read data, valid with done |
| seg_ld | input | 1 | Segment register load strobe |
| seg_ld_idx | input | 2 | Segment register to load |
| seg_ld_val | input | 16 | Value to load |
| bus_addr | output | 20 | Physical byte address |
| bus_stb | output | 1 | One-cycle bus strobe |
| bus_we | output | 1 | Bus write enable |
| bus_wdata | output | 8 | Bus write byte |
| bus_rdata | input | 8 | Bus read byte, valid with bus_rdy |
| bus_rdy | input | 1 | Bus cycle complete |

## Verification
The bench builds the unit with its default parameters: four 16-bit segments, a 4-bit shift, a 20-bit bus and a 16-bit word of two bytes. With these values, the real wrap points can be reached. A segment of FFFFh pushes the sum past 2^20, and offset FFFFh makes the second byte wrap inside 16 bits. Both can be checked against exact addresses. The bench's byte memory has a reply delay that can be set. The cycle count from request to done is therefore checked for delays of one and four cycles. The bench also runs a request injected while busy and a segment reload in mid-access.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_ISSUE = 2'd1,
    XS_WAIT  = 2'd2
  } xlate_state_t;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int NSEG  = 4,
  parameter int SEG_W = 16,
  localparam int SEL_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [SEL_W-1:0] ld_idx,
  input  logic [SEG_W-1:0] ld_val,
  input  logic [SEL_W-1:0] rd_idx,
  output logic [SEG_W-1:0] rd_val
);

  logic [SEG_W-1:0] seg_view [NSEG];

  for (genvar gi = 0; gi < NSEG; gi++) begin : g_seg
    logic [SEG_W-1:0] val_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        val_q <= '0;
      end else if (ld_en && (ld_idx == SEL_W'(gi))) begin
        val_q <= ld_val;
      end
    end
    assign seg_view[gi] = val_q;
  end

  // Registered contents are read, so a load in the accepting cycle is not seen.
  assign rd_val = seg_view[rd_idx];

endmodule

// File: rtl/phys_addr_calc.sv
module phys_addr_calc #(
  parameter int SEG_W     = 16,
  parameter int OFS_W     = 16,
  parameter int PADDR_W   = 20,
  parameter int SEG_SHIFT = 4,
  parameter int LANE_W    = 1,
  localparam int SH_W     = SEG_W + SEG_SHIFT
) (
  input  logic [SEG_W-1:0]   seg,
  input  logic [OFS_W-1:0]   ofs,
  input  logic [LANE_W-1:0]  lane,
  output logic [PADDR_W-1:0] addr
);

  logic [OFS_W-1:0] ofs_eff;
  logic [SH_W-1:0]  seg_sh;

  // The lane step wraps inside the offset width before the segment is added.
  assign ofs_eff = ofs + OFS_W'(lane);
  assign seg_sh  = {seg, {SEG_SHIFT{1'b0}}};
  assign addr    = PADDR_W'(seg_sh) + PADDR_W'(ofs_eff);

endmodule

// File: rtl/xlate_sequencer.sv
module xlate_sequencer
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W   = 16,
  parameter int OFS_W   = 16,
  parameter int PADDR_W = 20,
  parameter int BYTE_W  = 8,
  parameter int DATA_W  = 16,
  localparam int NLANE  = DATA_W / BYTE_W,
  localparam int LANE_W = (NLANE > 1) ? $clog2(NLANE) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_word,
  input  logic               req_write,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [SEG_W-1:0]   req_seg_val,
  input  logic [OFS_W-1:0]   req_ofs,
  output logic [SEG_W-1:0]   calc_seg,
  output logic [OFS_W-1:0]   calc_ofs,
  output logic [LANE_W-1:0]  calc_lane,
  input  logic [PADDR_W-1:0] calc_addr,
  output logic [PADDR_W-1:0] bus_addr,
  output logic               bus_stb,
  output logic               bus_we,
  output logic [BYTE_W-1:0]  bus_wdata,
  input  logic [BYTE_W-1:0]  bus_rdata,
  input  logic               bus_rdy,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  rd_data
);

  xlate_state_t      state_q;
  logic [LANE_W-1:0] lane_q;
  logic [LANE_W-1:0] last_q;
  logic [LANE_W-1:0] lane_nxt;
  logic [SEG_W-1:0]  held_seg;
  logic [OFS_W-1:0]  held_ofs;
  logic              held_we;
  logic [DATA_W-1:0] held_wdata;
  logic              accept;
  logic              capture;
  logic              final_byte;

  assign accept     = req_valid && (state_q == XS_IDLE);
  assign capture    = (state_q == XS_WAIT) && bus_rdy;
  assign final_byte = capture && (lane_q == last_q);
  assign lane_nxt   = lane_q + LANE_W'(1);

  // Address operands: live request when idle, held snapshot otherwise.
  always_comb begin
    if (state_q == XS_IDLE) begin
      calc_seg  = req_seg_val;
      calc_ofs  = req_ofs;
      calc_lane = '0;
    end else begin
      calc_seg  = held_seg;
      calc_ofs  = held_ofs;
      calc_lane = lane_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= XS_IDLE;
      lane_q     <= '0;
      last_q     <= '0;
      held_seg   <= '0;
      held_ofs   <= '0;
      held_we    <= 1'b0;
      held_wdata <= '0;
      bus_addr   <= '0;
      bus_stb    <= 1'b0;
      bus_we     <= 1'b0;
      bus_wdata  <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        XS_IDLE: begin
          if (accept) begin
            held_seg   <= req_seg_val;
            held_ofs   <= req_ofs;
            held_we    <= req_write;
            held_wdata <= req_wdata;
            lane_q     <= '0;
            last_q     <= req_word ? LANE_W'(NLANE - 1) : '0;
            bus_addr   <= calc_addr;
            bus_we     <= req_write;
            bus_wdata  <= req_wdata[BYTE_W-1:0];
            bus_stb    <= 1'b1;
            busy       <= 1'b1;
            state_q    <= XS_ISSUE;
          end
        end
        XS_ISSUE: begin
          bus_stb <= 1'b0;
          state_q <= XS_WAIT;
        end
        XS_WAIT: begin
          if (final_byte) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            state_q <= XS_IDLE;
          end else if (capture) begin
            lane_q    <= lane_nxt;
            bus_addr  <= calc_addr;
            bus_wdata <= held_wdata[lane_nxt*BYTE_W +: BYTE_W];
            bus_stb   <= 1'b1;
            state_q   <= XS_ISSUE;
          end
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  // One capture register per byte lane; lanes not read stay zero.
  for (genvar gi = 0; gi < NLANE; gi++) begin : g_lane
    logic [BYTE_W-1:0] acc_q;
    always_ff @(posedge clk) begin
      if (rst || accept) begin
        acc_q <= '0;
      end else if (capture && !held_we && (lane_q == LANE_W'(gi))) begin
        acc_q <= bus_rdata;
      end
    end
    assign rd_data[gi*BYTE_W +: BYTE_W] = acc_q;
  end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit #(
  parameter int NSEG      = 4,
  parameter int SEG_W     = 16,
  parameter int OFS_W     = 16,
  parameter int PADDR_W   = 20,
  parameter int SEG_SHIFT = 4,
  parameter int BYTE_W    = 8,
  parameter int DATA_W    = 16,
  localparam int SEL_W    = (NSEG > 1) ? $clog2(NSEG) : 1,
  localparam int NLANE    = DATA_W / BYTE_W,
  localparam int LANE_W   = (NLANE > 1) ? $clog2(NLANE) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [SEL_W-1:0]   req_seg,
  input  logic [OFS_W-1:0]   req_ofs,
  input  logic               req_word,
  input  logic               req_write,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               seg_ld,
  input  logic [SEL_W-1:0]   seg_ld_idx,
  input  logic [SEG_W-1:0]   seg_ld_val,
  output logic [PADDR_W-1:0] bus_addr,
  output logic               bus_stb,
  output logic               bus_we,
  output logic [BYTE_W-1:0]  bus_wdata,
  input  logic [BYTE_W-1:0]  bus_rdata,
  input  logic               bus_rdy
);

  logic [SEG_W-1:0]   sel_seg_val;
  logic [SEG_W-1:0]   calc_seg;
  logic [OFS_W-1:0]   calc_ofs;
  logic [LANE_W-1:0]  calc_lane;
  logic [PADDR_W-1:0] calc_addr;

  seg_regfile #(
    .NSEG  (NSEG),
    .SEG_W (SEG_W)
  ) u_segs (
    .clk    (clk),
    .rst    (rst),
    .ld_en  (seg_ld),
    .ld_idx (seg_ld_idx),
    .ld_val (seg_ld_val),
    .rd_idx (req_seg),
    .rd_val (sel_seg_val)
  );

  phys_addr_calc #(
    .SEG_W     (SEG_W),
    .OFS_W     (OFS_W),
    .PADDR_W   (PADDR_W),
    .SEG_SHIFT (SEG_SHIFT),
    .LANE_W    (LANE_W)
  ) u_addr (
    .seg  (calc_seg),
    .ofs  (calc_ofs),
    .lane (calc_lane),
    .addr (calc_addr)
  );

  xlate_sequencer #(
    .SEG_W   (SEG_W),
    .OFS_W   (OFS_W),
    .PADDR_W (PADDR_W),
    .BYTE_W  (BYTE_W),
    .DATA_W  (DATA_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_word    (req_word),
    .req_write   (req_write),
    .req_wdata   (req_wdata),
    .req_seg_val (sel_seg_val),
    .req_ofs     (req_ofs),
    .calc_seg    (calc_seg),
    .calc_ofs    (calc_ofs),
    .calc_lane   (calc_lane),
    .calc_addr   (calc_addr),
    .bus_addr    (bus_addr),
    .bus_stb     (bus_stb),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .bus_rdy     (bus_rdy),
    .busy        (busy),
    .done        (done),
    .rd_data     (rd_data)
  );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int PADDR_W = 20
) (
  input logic               clk,
  input logic               rst,
  input logic               busy,
  input logic               done,
  input logic               bus_stb,
  input logic [PADDR_W-1:0] bus_addr
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done && !bus_stb));

  // R8
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    bus_stb |=> !bus_stb);

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_stb |=> $stable(bus_addr));

  // R9
  stb_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    bus_stb |-> busy);

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

bind seg_xlate_unit seg_xlate_chk #(.PADDR_W(PADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .bus_stb  (bus_stb),
  .bus_addr (bus_addr)
);

// File: tb/seg_xlate_unit_test.sv
`timescale 1ns/1ps
module seg_xlate_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_seg = '0;
  logic [15:0] req_ofs = '0;
  logic        req_word = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        busy, done;
  logic [15:0] rd_data;
  logic        seg_ld = 1'b0;
  logic [1:0]  seg_ld_idx = '0;
  logic [15:0] seg_ld_val = '0;
  logic [19:0] bus_addr;
  logic        bus_stb, bus_we;
  logic [7:0]  bus_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_rdy = 1'b0;

  always #2 clk = ~clk;

  seg_xlate_unit uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_seg(req_seg),
    .req_ofs(req_ofs), .req_word(req_word), .req_write(req_write),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
    .seg_ld(seg_ld), .seg_ld_idx(seg_ld_idx), .seg_ld_val(seg_ld_val),
    .bus_addr(bus_addr), .bus_stb(bus_stb), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(mem_rdata), .bus_rdy(mem_rdy)
  );

  // Behavioural byte memory, aliased on the low 12 address bits.
  logic [7:0]  mem [4096];
  int          lat = 1;
  int          cnt = 0;
  bit          pend = 0;
  bit          stb_d = 0;
  logic [19:0] p_addr;
  bit          p_we;
  logic [7:0]  p_wd;
  int          stb_cnt = 0;
  int          width_err = 0;
  logic [19:0] stb_log [4];

  always @(posedge clk) begin
    mem_rdy <= 1'b0;
    if (bus_stb) begin
      if (stb_d) width_err++;
      if (stb_cnt < 4) stb_log[stb_cnt] = bus_addr;
      stb_cnt++;
      pend = 1; cnt = lat;
      p_addr = bus_addr; p_we = bus_we; p_wd = bus_wdata;
    end
    if (pend) begin
      if (cnt <= 1) begin
        pend = 0;
        mem_rdy <= 1'b1;
        if (p_we) mem[p_addr[11:0]] = p_wd;
        else mem_rdata <= mem[p_addr[11:0]];
      end else begin
        cnt--;
      end
    end
    stb_d = bus_stb;
  end

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic load_seg(input logic [1:0] idx, input logic [15:0] val);
    @(negedge clk);
    seg_ld = 1'b1; seg_ld_idx = idx; seg_ld_val = val;
    @(negedge clk);
    seg_ld = 1'b0;
  endtask

  bit busy_mid;

  // Issues one request; cyc is the number of negedges until done is seen.
  task automatic run_op(input logic [1:0] s, input logic [15:0] o, input bit w,
                        input bit wr, input logic [15:0] wd, input bit inject,
                        input bit reload, output int cyc);
    @(negedge clk);
    stb_cnt = 0;
    req_seg = s; req_ofs = o; req_word = w; req_write = wr; req_wdata = wd;
    req_valid = 1'b1;
    cyc = 0;
    @(negedge clk);
    cyc = 1;
    req_valid = 1'b0;
    if (reload) begin seg_ld = 1'b1; seg_ld_idx = s; seg_ld_val = 16'h2000; end
    while (!done && cyc < 200) begin
      if (inject && cyc == 2) begin
        busy_mid = busy;
        req_valid = 1'b1; req_ofs = 16'h0777; req_seg = 2'd1;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      seg_ld = 1'b0;
      cyc++;
    end
    req_valid = 1'b0;
  endtask

  typedef struct packed {
    logic [1:0]  seg;
    logic [15:0] ofs;
    logic        word;
    logic        wr;
    logic [15:0] wdata;
    logic [19:0] a0;
    logic [19:0] a1;
    logic [15:0] rexp;
  } vec_t;

  // Segments: 0=1000h, 1=2345h, 2=FFFFh, 3=0000h
  localparam vec_t VEC [10] = '{
    '{2'd0, 16'h0002, 1'b1, 1'b1, 16'h1234, 20'h10002, 20'h10003, 16'h0000},
    '{2'd0, 16'h0002, 1'b1, 1'b0, 16'h0000, 20'h10002, 20'h10003, 16'h1234},
    '{2'd1, 16'h0010, 1'b0, 1'b1, 16'h77AB, 20'h23460, 20'h00000, 16'h0000},
    '{2'd1, 16'h0010, 1'b0, 1'b0, 16'h0000, 20'h23460, 20'h00000, 16'h00AB},
    '{2'd2, 16'h0010, 1'b1, 1'b1, 16'hBEEF, 20'h00000, 20'h00001, 16'h0000},
    '{2'd2, 16'h0010, 1'b1, 1'b0, 16'h0000, 20'h00000, 20'h00001, 16'hBEEF},
    '{2'd3, 16'hFFFF, 1'b1, 1'b1, 16'h5A6B, 20'h0FFFF, 20'h00000, 16'h0000},
    '{2'd3, 16'hFFFF, 1'b1, 1'b0, 16'h0000, 20'h0FFFF, 20'h00000, 16'h5A6B},
    '{2'd1, 16'h1234, 1'b1, 1'b1, 16'hC0DE, 20'h24684, 20'h24685, 16'h0000},
    '{2'd1, 16'h1234, 1'b1, 1'b0, 16'h0000, 20'h24684, 20'h24685, 16'hC0DE}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R8: watchdog expired, actual hung expected done");
    summary();
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R1: held reset
    chk(!busy && !done && !bus_stb, "R1 in reset", {busy, done, bus_stb}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !bus_stb, "R1 after reset", {busy, done, bus_stb}, 0);

    load_seg(2'd0, 16'h1000);
    load_seg(2'd1, 16'h2345);
    load_seg(2'd2, 16'hFFFF);
    load_seg(2'd3, 16'h0000);

    for (int i = 0; i < 10; i++) begin
      vec_t v;
      v = VEC[i];
      run_op(v.seg, v.ofs, v.word, v.wr, v.wdata, 1'b0, 1'b0, cyc);
      chk(stb_log[0] == v.a0, $sformatf("R2 R3 vec %0d first address", i), 32'(stb_log[0]), 32'(v.a0));
      chk(stb_cnt == (v.word ? 2 : 1), $sformatf("R6 vec %0d strobe count", i), stb_cnt, v.word ? 2 : 1);
      chk(cyc == (v.word ? 5 : 3), $sformatf("R8 vec %0d latency", i), cyc, v.word ? 5 : 3);
      if (v.word)
        chk(stb_log[1] == v.a1, $sformatf("R4 R7 R11 vec %0d second address", i), 32'(stb_log[1]), 32'(v.a1));
      if (!v.wr)
        chk(rd_data == v.rexp, $sformatf("R5 R6 vec %0d read data", i), 32'(rd_data), 32'(v.rexp));
      if (i == 0) begin
        chk(mem[12'h002] == 8'h34, "R4 low byte at lower address", 32'(mem[12'h002]), 32'h34);
        chk(mem[12'h003] == 8'h12, "R4 high byte at upper address", 32'(mem[12'h003]), 32'h12);
      end
    end

    // R11: FFFFh:0010h wraps to 00000h
    chk(mem[12'h000] == 8'h5A && mem[12'h001] == 8'hBE, "R11 wrapped bytes", {mem[12'h000], mem[12'h001]}, 32'h5ABE);
    // R7: second byte of FFFFh offset landed at 00000h
    chk(mem[12'hFFF] == 8'h6B, "R7 first byte at 0FFFFh", 32'(mem[12'hFFF]), 32'h6B);

    // R5: done is a single-cycle pulse
    run_op(2'd0, 16'h0002, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, cyc);
    chk(done == 1'b1 && busy == 1'b0, "R9 busy low with done", {done, busy}, 32'h2);
    @(negedge clk);
    chk(done == 1'b0, "R5 done pulse width", done, 0);

    // R8: reply delay of four cycles
    lat = 4;
    run_op(2'd1, 16'h1234, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, cyc);
    chk(cyc == 11, "R8 latency with slow ready", cyc, 11);
    chk(rd_data == 16'hC0DE, "R8 data with slow ready", 32'(rd_data), 32'hC0DE);
    lat = 1;
    chk(width_err == 0, "R8 strobe width", width_err, 0);

    // R9: request while busy is ignored
    run_op(2'd1, 16'h0010, 1'b0, 1'b0, 16'h0, 1'b1, 1'b0, cyc);
    chk(busy_mid == 1'b1, "R9 busy during access", busy_mid, 1);
    chk(rd_data == 16'h00AB, "R9 data unaffected", 32'(rd_data), 32'h00AB);
    repeat (8) @(negedge clk);
    chk(stb_cnt == 1, "R9 no strobe from ignored request", stb_cnt, 1);
    chk(!busy, "R9 idle after ignored request", busy, 0);

    // R10: reload segment 0 during an access
    run_op(2'd0, 16'h0002, 1'b1, 1'b0, 16'h0, 1'b0, 1'b1, cyc);
    chk(stb_log[0] == 20'h10002 && stb_log[1] == 20'h10003, "R10 in-flight keeps old segment",
        32'(stb_log[1]), 32'h10003);
    chk(rd_data == 16'h1234, "R10 in-flight data", 32'(rd_data), 32'h1234);
    run_op(2'd0, 16'h0002, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, cyc);
    chk(stb_log[0] == 20'h20002, "R10 R3 next request uses new segment", 32'(stb_log[0]), 32'h20002);

    summary();
  end

endmodule